// File: doc/BRIEF.md
# Programmable LCD Display Timing Generator

This block drives the sync and data-enable lines of a parallel RGB panel, and the colour that goes with them, from a small set of timing words written through a plain write port. A single pixel-clock counter walks the whole frame. The line position is kept next to it and returns to zero at every line end and at the frame end. Horizontal limits are compared against the line position. Vertical limits are compared against the absolute frame position, so software can move the vertical window edges part way into a line to add a sync skew.

Inside the display window the generator can mark a smaller active window. Each axis of that window has its own enable flag. Display pixels outside the active window show a programmable border colour. Active pixels are pulled from a show-ahead pixel FIFO through a same-cycle pop. If the FIFO is empty when a pixel is needed, the block goes into underflow and shows an underflow colour. With recovery enabled, it leaves underflow at the next frame start. Without recovery, it stays in underflow until the generator is stopped. A one-clock frame-start strobe marks frame position zero.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset all timing words are zero and the generator is stopped. Outputs are idle: hsync, vsync, data enable, frame start and pop are 0, and the colour is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the word at `cfg_addr` at that clock edge. The word addresses are:
  - 0: run, bit 0.
  - 1: line length in bits 31:16, hsync width in bits 15:0.
  - 2: frame length in clocks.
  - 3: vsync length in clocks.
  - 4: display horizontal end in bits 31:16, start in bits 15:0.
  - 5: display vertical start.
  - 6: display vertical end.
  - 7: active horizontal window: enable in bit 31, end in bits 27:16, start in bits 11:0.
  - 8: active vertical start, with its enable in bit 31.
  - 9: active vertical end.
  - 10: border colour.
  - 11: underflow colour, with recovery enable in bit 31.
  - 12: polarity.
- R3: While running, the frame position counts 0 to frame length − 1 and wraps. The registered outputs describe the position the counter held one clock earlier. `frame_start` is high for exactly the one clock that shows position 0.
- R4: hsync is active while the line position is below the hsync width. The line position is the frame position modulo the line length.
- R5: vsync is active while the frame position is below the vsync length.
- R6: Data enable is active when the line position lies within the display horizontal start and end, and the frame position lies within the display vertical start and end. All bounds are inclusive.
- R7: When its enable bit is set, the active horizontal range further limits which display pixels are active. The active vertical range does the same, under its own enable bit. When an axis is disabled, that axis covers the whole display window.
- R8: At an active position, with no underflow and `pix_empty` low, `pix_pop` is high in the same cycle and the next colour is `pix_data`. A display pixel that is not active shows the border colour. Outside the display window the colour is 0.
- R9: Polarity bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data enable. A bit of 1 means active-low, and the inverted idle level is driven while stopped.
- R10: An active position with `pix_empty` high starts underflow. In underflow, active pixels show the underflow colour and nothing is popped.
- R11: With recovery set, underflow ends at frame position 0 and popping resumes in that frame. With recovery clear, underflow lasts until the generator is stopped.
- R12: Writing 0 to the run word stops the generator. From the next clock the counters are 0, the outputs are idle and underflow is cleared. A later start begins again at frame position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_addr | input | 4 | Timing word address |
| cfg_wdata | input | 32 | Timing word write data |
| pix_empty | input | 1 | Pixel FIFO empty |
| pix_data | input | RGB_W | Pixel at the FIFO head |
| pix_pop | output | 1 | Pop the FIFO head this cycle |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_de | output | 1 | Data enable |
| lcd_rgb | output | RGB_W | Pixel colour |
| frame_start | output | 1 | One-clock strobe at frame position 0 |

## Verification
A reference model in the bench tracks the frame and line positions and the underflow state, and is compared with every output on every clock. The first pattern keeps the FIFO full, uses no active window and no skew. It separates sync widths, display bounds and strobe placement. The second pattern adds a skew of three clocks, inverts all polarities and enables both active ranges. This shows whether vertical bounds are compared as clock positions rather than lines, and whether border pixels are told apart from active ones. Two further patterns starve the FIFO part way through a frame and refill it before the next frame, once with recovery and once without. The pop counts then show whether underflow ends at the frame boundary or only on a stop and restart.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

  localparam int unsigned CFG_AW   = 4;
  localparam int unsigned CFG_DW   = 32;
  localparam int unsigned NUM_WORDS = 13;
  localparam int unsigned HI_LSB   = 16;
  localparam int unsigned FLAG_BIT = 31;

  localparam int unsigned POL_HS = 0;
  localparam int unsigned POL_VS = 1;
  localparam int unsigned POL_DE = 2;

  typedef enum logic [CFG_AW-1:0] {
    W_RUN      = 4'd0,
    W_HLINE    = 4'd1,
    W_FRAME    = 4'd2,
    W_VPULSE   = 4'd3,
    W_DISP_H   = 4'd4,
    W_DISP_VS  = 4'd5,
    W_DISP_VE  = 4'd6,
    W_ACT_H    = 4'd7,
    W_ACT_VS   = 4'd8,
    W_ACT_VE   = 4'd9,
    W_BORDER   = 4'd10,
    W_UFLOW    = 4'd11,
    W_POLARITY = 4'd12
  } cfg_word_e;

endpackage

// File: rtl/lcd_tg_cfg.sv
module lcd_tg_cfg
  import lcd_tg_pkg::*;
#(
  parameter int unsigned WORDS = NUM_WORDS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [CFG_AW-1:0]             addr,
  input  logic [CFG_DW-1:0]             wdata,
  output logic [WORDS-1:0][CFG_DW-1:0]  words
);

  logic [WORDS-1:0][CFG_DW-1:0] words_d;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit;

    always_comb begin
      hit        = we && (addr == CFG_AW'(g));
      words_d[g] = hit ? wdata : words[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else if (hit) begin
        words[g] <= words_d[g];
      end
    end

    // R2: a write lands in the addressed word at the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == CFG_AW'(g)) |=> (words[g] == $past(wdata)));
  end

  // R2: without a write strobe no word changes
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(words));

endmodule

// File: rtl/lcd_tg_counters.sv
module lcd_tg_counters #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned H_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] frame_len,
  input  logic [H_W-1:0]   line_len,
  output logic [CNT_W-1:0] fpos,
  output logic [H_W-1:0]   lpos
);

  logic             f_last;
  logic             l_last;
  logic [CNT_W-1:0] fpos_d;
  logic [H_W-1:0]   lpos_d;

  always_comb begin
    f_last = (fpos == frame_len - CNT_W'(1));
    l_last = (lpos == line_len - H_W'(1));
    if (!run) begin
      fpos_d = '0;
      lpos_d = '0;
    end else begin
      fpos_d = f_last ? '0 : fpos + CNT_W'(1);
      lpos_d = (f_last || l_last) ? '0 : lpos + H_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpos <= '0;
      lpos <= '0;
    end else begin
      fpos <= fpos_d;
      lpos <= lpos_d;
    end
  end

  // R12: a stopped generator holds both positions at zero
  a_r12_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (fpos == '0 && lpos == '0));

  // R3: the frame position steps by one until its last value
  a_r3_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fpos != frame_len - CNT_W'(1)) |=> (fpos == $past(fpos) + CNT_W'(1)));

  // R3: the frame end returns both positions to zero
  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fpos == frame_len - CNT_W'(1)) |=> (fpos == '0 && lpos == '0));

endmodule

// File: rtl/lcd_tg_window.sv
module lcd_tg_window #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned H_W   = 12
) (
  input  logic [CNT_W-1:0] fpos,
  input  logic [H_W-1:0]   lpos,
  input  logic [H_W-1:0]   hs_width,
  input  logic [CNT_W-1:0] vs_len,
  input  logic [H_W-1:0]   dh_start,
  input  logic [H_W-1:0]   dh_end,
  input  logic [CNT_W-1:0] dv_start,
  input  logic [CNT_W-1:0] dv_end,
  input  logic             ah_on,
  input  logic [H_W-1:0]   ah_start,
  input  logic [H_W-1:0]   ah_end,
  input  logic             av_on,
  input  logic [CNT_W-1:0] av_start,
  input  logic [CNT_W-1:0] av_end,
  output logic             hs_on,
  output logic             vs_on,
  output logic             disp_on,
  output logic             act_on
);

  logic in_dh, in_dv, in_ah, in_av;

  always_comb begin
    hs_on   = (lpos < hs_width);
    vs_on   = (fpos < vs_len);
    in_dh   = (lpos >= dh_start) && (lpos <= dh_end);
    in_dv   = (fpos >= dv_start) && (fpos <= dv_end);
    in_ah   = !ah_on || ((lpos >= ah_start) && (lpos <= ah_end));
    in_av   = !av_on || ((fpos >= av_start) && (fpos <= av_end));
    disp_on = in_dh && in_dv;
    act_on  = disp_on && in_ah && in_av;
  end

endmodule

// File: rtl/lcd_tg_pixout.sv
module lcd_tg_pixout #(
  parameter int unsigned RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pos_first,
  input  logic             hs_on,
  input  logic             vs_on,
  input  logic             disp_on,
  input  logic             act_on,
  input  logic [2:0]       pol,
  input  logic [RGB_W-1:0] border,
  input  logic [RGB_W-1:0] uf_colour,
  input  logic             recover,
  input  logic             pix_empty,
  input  logic [RGB_W-1:0] pix_data,
  output logic             pix_pop,
  output logic             lcd_hsync,
  output logic             lcd_vsync,
  output logic             lcd_de,
  output logic [RGB_W-1:0] lcd_rgb,
  output logic             frame_start
);

  logic             uf_q, uf_d, uf_eff, need;
  logic             hs_d, vs_d, de_d, fs_d;
  logic [RGB_W-1:0] rgb_d;

  always_comb begin
    uf_eff  = uf_q && !(recover && pos_first);
    need    = run && act_on;
    pix_pop = need && !uf_eff && !pix_empty;
    uf_d    = run && (uf_eff || (need && pix_empty));
    hs_d    = (run && hs_on)   ^ pol[0];
    vs_d    = (run && vs_on)   ^ pol[1];
    de_d    = (run && disp_on) ^ pol[2];
    fs_d    = run && pos_first;
    if (!run)         rgb_d = '0;
    else if (need)    rgb_d = pix_pop ? pix_data : uf_colour;
    else if (disp_on) rgb_d = border;
    else              rgb_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q        <= 1'b0;
      lcd_hsync   <= 1'b0;
      lcd_vsync   <= 1'b0;
      lcd_de      <= 1'b0;
      lcd_rgb     <= '0;
      frame_start <= 1'b0;
    end else begin
      uf_q        <= uf_d;
      lcd_hsync   <= hs_d;
      lcd_vsync   <= vs_d;
      lcd_de      <= de_d;
      lcd_rgb     <= rgb_d;
      frame_start <= fs_d;
    end
  end

  // R8: a pop is only requested when the FIFO holds a pixel
  a_r8_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    pix_pop |-> !pix_empty);

  // R8: a popped pixel appears on the colour output next clock
  a_r8_pop_shows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_pop |=> (lcd_rgb == $past(pix_data)));

  // R10: underflow blocks popping away from the frame boundary
  a_r10_uf_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_q && !pos_first) |-> !pix_pop);

  // R11: without recovery underflow persists while running
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_q && run && !recover) |=> uf_q);

  // R12: a stop leaves idle colour, no strobe and no underflow
  a_r12_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (lcd_rgb == '0 && !frame_start && !uf_q));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned H_W   = 12,
  parameter int unsigned RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             pix_empty,
  input  logic [RGB_W-1:0] pix_data,
  output logic             pix_pop,
  output logic             lcd_hsync,
  output logic             lcd_vsync,
  output logic             lcd_de,
  output logic [RGB_W-1:0] lcd_rgb,
  output logic             frame_start
);

  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic [NUM_WORDS-1:0][CFG_DW-1:0] words;

  lcd_tg_cfg #(.WORDS(NUM_WORDS)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .words (words)
  );

  logic             run;
  logic [H_W-1:0]   line_len, hs_width, dh_start, dh_end, ah_start, ah_end;
  logic [CNT_W-1:0] frame_len, vs_len, dv_start, dv_end, av_start, av_end;
  logic             ah_on, av_on, recover;
  logic [2:0]       pol;
  logic [RGB_W-1:0] border, uf_colour;

  always_comb begin
    run       = words[W_RUN][0];
    line_len  = words[W_HLINE][HI_LSB +: H_W];
    hs_width  = words[W_HLINE][0 +: H_W];
    frame_len = words[W_FRAME][0 +: CNT_W];
    vs_len    = words[W_VPULSE][0 +: CNT_W];
    dh_end    = words[W_DISP_H][HI_LSB +: H_W];
    dh_start  = words[W_DISP_H][0 +: H_W];
    dv_start  = words[W_DISP_VS][0 +: CNT_W];
    dv_end    = words[W_DISP_VE][0 +: CNT_W];
    ah_on     = words[W_ACT_H][FLAG_BIT];
    ah_end    = words[W_ACT_H][HI_LSB +: H_W];
    ah_start  = words[W_ACT_H][0 +: H_W];
    av_on     = words[W_ACT_VS][FLAG_BIT];
    av_start  = words[W_ACT_VS][0 +: CNT_W];
    av_end    = words[W_ACT_VE][0 +: CNT_W];
    border    = words[W_BORDER][0 +: RGB_W];
    recover   = words[W_UFLOW][FLAG_BIT];
    uf_colour = words[W_UFLOW][0 +: RGB_W];
    pol       = {words[W_POLARITY][POL_DE], words[W_POLARITY][POL_VS],
                 words[W_POLARITY][POL_HS]};
  end

  logic [CNT_W-1:0] fpos;
  logic [H_W-1:0]   lpos;

  lcd_tg_counters #(.CNT_W(CNT_W), .H_W(H_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run       (run),
    .frame_len (frame_len),
    .line_len  (line_len),
    .fpos      (fpos),
    .lpos      (lpos)
  );

  logic hs_on, vs_on, disp_on, act_on;

  lcd_tg_window #(.CNT_W(CNT_W), .H_W(H_W)) u_win (
    .fpos     (fpos),
    .lpos     (lpos),
    .hs_width (hs_width),
    .vs_len   (vs_len),
    .dh_start (dh_start),
    .dh_end   (dh_end),
    .dv_start (dv_start),
    .dv_end   (dv_end),
    .ah_on    (ah_on),
    .ah_start (ah_start),
    .ah_end   (ah_end),
    .av_on    (av_on),
    .av_start (av_start),
    .av_end   (av_end),
    .hs_on    (hs_on),
    .vs_on    (vs_on),
    .disp_on  (disp_on),
    .act_on   (act_on)
  );

  lcd_tg_pixout #(.RGB_W(RGB_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .run         (run),
    .pos_first   (fpos == '0),
    .hs_on       (hs_on),
    .vs_on       (vs_on),
    .disp_on     (disp_on),
    .act_on      (act_on),
    .pol         (pol),
    .border      (border),
    .uf_colour   (uf_colour),
    .recover     (recover),
    .pix_empty   (pix_empty),
    .pix_data    (pix_data),
    .pix_pop     (pix_pop),
    .lcd_hsync   (lcd_hsync),
    .lcd_vsync   (lcd_vsync),
    .lcd_de      (lcd_de),
    .lcd_rgb     (lcd_rgb),
    .frame_start (frame_start)
  );

  // R3: the frame strobe is one clock wide on any frame longer than one clock
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frame_start && run && frame_len > CNT_W'(1)) |=> !frame_start);

endmodule

// File: tb/lcd_timing_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb_top;

  localparam int RGB_W = 24;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we = 1'b0;
  logic [3:0]       cfg_addr = '0;
  logic [31:0]      cfg_wdata = '0;
  logic             pix_empty = 1'b1;
  logic [RGB_W-1:0] pix_data = '0;
  logic             pix_pop, lcd_hsync, lcd_vsync, lcd_de, frame_start;
  logic [RGB_W-1:0] lcd_rgb;

  always #2 clk = ~clk;

  lcd_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_empty(pix_empty), .pix_data(pix_data),
    .pix_pop(pix_pop), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
    .lcd_de(lcd_de), .lcd_rgb(lcd_rgb), .frame_start(frame_start)
  );

  int    checks = 0;
  int    errors = 0;
  string phase = "R1_reset";
  bit    done = 0;

  logic [31:0]      mreg [13];
  int               mf, mh;
  bit               muf;
  logic             e_hs, e_vs, e_de, e_fs;
  logic [RGB_W-1:0] e_rgb;
  logic [RGB_W-1:0] pq[$];
  bit               force_empty = 0;
  int               pops = 0, border_seen = 0, uc_seen = 0, fs_seen = 0;

  task automatic chk(string req, string sig, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s [%s] actual=%0h expected=%0h", req, sig, phase, act, exp);
    end
  endtask

  function automatic bit m_disp();
    int dhs = mreg[4][15:0], dhe = mreg[4][31:16];
    int dvs = mreg[5][23:0], dve = mreg[6][23:0];
    return mh >= dhs && mh <= dhe && mf >= dvs && mf <= dve;
  endfunction

  function automatic bit m_act();
    bit okh = !mreg[7][31] || (mh >= mreg[7][11:0] && mh <= mreg[7][27:16]);
    bit okv = !mreg[8][31] || (mf >= mreg[8][23:0] && mf <= mreg[9][23:0]);
    return m_disp() && okh && okv;
  endfunction

  function automatic bit m_ufe();
    return muf && !(mreg[11][31] && mf == 0);
  endfunction

  function automatic bit m_pop();
    return mreg[0][0] && m_act() && !m_ufe() && !pix_empty;
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 13; i++) mreg[i] = '0;
      mf = 0; mh = 0; muf = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_fs = 0; e_rgb = '0;
    end else if (mreg[0][0]) begin
      bit act, disp, ufe, pop;
      int lp, fp;
      act  = m_act();
      disp = m_disp();
      ufe  = m_ufe();
      pop  = m_pop();
      lp   = mreg[1][31:16];
      fp   = mreg[2][23:0];
      e_hs = (mh < mreg[1][15:0]) ^ mreg[12][0];
      e_vs = (mf < mreg[3][23:0]) ^ mreg[12][1];
      e_de = disp ^ mreg[12][2];
      e_fs = (mf == 0);
      if (act) begin
        if (pop) begin
          e_rgb = pq.pop_front();
          pops++;
        end else begin
          e_rgb = mreg[11][23:0];
          uc_seen++;
        end
      end else if (disp) begin
        e_rgb = mreg[10][23:0];
        border_seen++;
      end else begin
        e_rgb = '0;
      end
      muf = ufe || (act && pix_empty);
      if (mf == fp - 1) begin mf = 0; mh = 0; end
      else begin
        mf = mf + 1;
        mh = (mh == lp - 1) ? 0 : mh + 1;
      end
      if (cfg_we) mreg[cfg_addr] = cfg_wdata;
    end else begin
      e_hs = mreg[12][0]; e_vs = mreg[12][1]; e_de = mreg[12][2];
      e_fs = 0; e_rgb = '0; muf = 0; mf = 0; mh = 0;
      if (cfg_we) mreg[cfg_addr] = cfg_wdata;
    end
  end

  // input drive and per-clock comparison, away from the rising edge
  always @(negedge clk) begin
    pix_empty = force_empty || pq.size() == 0;
    pix_data  = (pq.size() != 0) ? pq[0] : '0;
    #1;
    if (rst_n === 1'b1 && !done) begin
      chk("R4 R9", "hsync", lcd_hsync, e_hs);
      chk("R5 R9", "vsync", lcd_vsync, e_vs);
      chk("R6 R9", "de", lcd_de, e_de);
      chk("R3", "frame_start", frame_start, e_fs);
      chk("R8", "rgb", lcd_rgb, e_rgb);
      chk("R8", "pop", pix_pop, m_pop());
      if (frame_start === 1'b1) fs_seen++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 15-clock lines, 8 lines per frame, display 8 x 4
  task automatic setup(input int skew, input logic [2:0] pol, input bit win,
                       input logic [31:0] uflow);
    int avs;
    avs = 60 + skew;
    wr(4'd1, {16'd15, 16'd2});
    wr(4'd2, 32'd120);
    wr(4'd3, 32'd15);
    wr(4'd4, {16'd12, 16'd5});
    wr(4'd5, 32'(45 + skew));
    wr(4'd6, 32'(104 + skew));
    wr(4'd7, win ? (32'h8000_0000 | (32'd10 << 16) | 32'd7) : 32'd0);
    wr(4'd8, win ? (32'h8000_0000 | 32'(avs)) : 32'd0);
    wr(4'd9, win ? 32'(avs + 29) : 32'd0);
    wr(4'd10, 32'h00AA55);
    wr(4'd11, uflow);
    wr(4'd12, {29'd0, pol});
  endtask

  task automatic fill(input int n, input int base);
    for (int i = 0; i < n; i++) pq.push_back(RGB_W'(base + i));
  endtask

  initial begin
    rst_n = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    // R1: idle state after reset
    chk("R1", "hsync", lcd_hsync, 0);
    chk("R1", "vsync", lcd_vsync, 0);
    chk("R1", "de", lcd_de, 0);
    chk("R1", "rgb", lcd_rgb, 0);
    chk("R1", "frame_start", frame_start, 0);
    chk("R1", "pop", pix_pop, 0);

    phase = "R2_R3_R4_R5_R6_base";
    setup(0, 3'b000, 0, 32'h0000_00FF);
    fill(100, 16'h100);
    fs_seen = 0;
    wr(4'd0, 32'd1);
    idle(239);
    chk("R3", "frame_count", fs_seen, 2);
    wr(4'd0, 32'd0);

    phase = "R12_stop";
    idle(10);
    chk("R12", "de", lcd_de, 0);
    chk("R12", "rgb", lcd_rgb, 0);
    chk("R12", "pop", pix_pop, 0);

    phase = "R7_R9_window";
    pq.delete();
    setup(3, 3'b111, 1, 32'h0000_00FF);
    fill(40, 16'h200);
    border_seen = 0;
    wr(4'd0, 32'd1);
    idle(250);
    chk("R7", "border_seen", 32'(border_seen > 0), 1);
    wr(4'd0, 32'd0);
    idle(4);
    chk("R9", "hsync_idle", lcd_hsync, 1);

    phase = "R11_recover";
    pq.delete();
    setup(0, 3'b000, 0, 32'h8000_F0F0);
    fill(10, 16'h300);
    pops = 0; uc_seen = 0;
    wr(4'd0, 32'd1);
    idle(110);
    fill(64, 16'h400);
    idle(150);
    chk("R11", "pops_after_recovery", 32'(pops > 10), 1);
    chk("R10", "uflow_seen", 32'(uc_seen > 0), 1);
    wr(4'd0, 32'd0);

    phase = "R10_hold";
    pq.delete();
    setup(0, 3'b000, 0, 32'h0000_0F0F);
    fill(10, 16'h500);
    pops = 0; uc_seen = 0;
    wr(4'd0, 32'd1);
    idle(110);
    fill(64, 16'h600);
    idle(150);
    chk("R10", "pops_without_recovery", pops, 10);
    chk("R10", "uflow_seen", 32'(uc_seen > 0), 1);
    wr(4'd0, 32'd0);

    phase = "R12_restart";
    idle(6);
    pops = 0;
    fs_seen = 0;
    wr(4'd0, 32'd1);
    idle(130);
    chk("R12", "pops_after_restart", 32'(pops > 0), 1);
    chk("R12", "frame_restart", 32'(fs_seen > 0), 1);
    wr(4'd0, 32'd0);
    idle(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog [%s] actual=running expected=finished", phase);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule